// File: doc/BRIEF.md
# USB Endpoint NAK Gating Controller

This block sits beside a USB device core and decides, for every token the host sends, whether the endpoint must answer with NAK. Software needs time to react to some bus events. This block gives it that time. Three event pulses come from the device core: a configuration change, an end of transfer on a bulk OUT endpoint, and a received setup packet. Each event sets a sticky interrupt bit. While a bit is set, it holds a NAK whose reach depends on the event:

- A configuration change NAKs every endpoint in both directions.
- An end of transfer NAKs OUT traffic on its own endpoint only.
- A setup packet NAKs both directions on its own endpoint.

A second setup packet on an endpoint whose request bit is still set raises a separate overrun bit.

Software reads the bit vector and clears bits with a write-one-to-clear access. A second register address holds an interrupt enable mask. The interrupt line is the OR of all enabled set bits. The force-NAK answer is combinational, so the core gets it in the same cycle it presents the token's endpoint and direction.

Top module: `ep_nak_gate`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every status bit, the enable mask and `irq`. After reset, `force_nak` is 0 for any token.
- R2: A `cfg_evt` pulse sets status bit 0. While bit 0 is set, every valid token is NAKed, on any endpoint and in either direction.
- R3: An `eot_evt` pulse on a bulk OUT endpoint `n` sets status bit `2+n`. While that bit is set, OUT tokens (`tok_dir_in`=0) on endpoint `n` are NAKed. IN tokens on `n` and tokens on other endpoints are not affected by it.
- R4: An `eot_evt` on an endpoint not flagged in `BULK_OUT_MASK` is ignored. The default flags endpoints 2 and 5, so endpoint 0, which is control, is never bulk OUT. An `eot_evt` on an index of `NUM_EP` or above is also ignored.
- R5: A `setup_evt` pulse on endpoint `n` sets status bit `2+NUM_EP+n`. While that bit is set, both IN and OUT tokens on endpoint `n` are NAKed.
- R6: A `setup_evt` on endpoint `n` while bit `2+NUM_EP+n` is already set also sets the overrun bit, status bit 1. The overrun bit causes no NAK by itself.
- R7: A status bit is cleared only by a write to address 0 with a 1 in that bit position. Bits written as 0 keep their value, and no bit clears itself.
- R8: When an event and a clear of the same bit fall in the same cycle, the bit stays set.
- R9: `force_nak` is combinational. It is valid in the same cycle as `tok_valid`, `tok_ep` and `tok_dir_in`, and it is 0 whenever `tok_valid` is 0.
- R10: A write to address 1 loads the enable mask, which uses the same bit layout as the status. `irq` equals the OR of status AND mask, and both update on the same clock edge.
- R11: A `setup_evt` on an index of `NUM_EP` or above is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_evt | input | 1 | Configuration change pulse |
| eot_evt | input | 1 | End-of-transfer pulse |
| eot_ep | input | EPW | Endpoint of the end-of-transfer pulse |
| setup_evt | input | 1 | Setup packet received pulse |
| setup_ep | input | EPW | Endpoint of the setup pulse |
| tok_valid | input | 1 | A token is being presented |
| tok_ep | input | EPW | Endpoint index of the token |
| tok_dir_in | input | 1 | 1 for an IN token, 0 for OUT |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects clear, 1 selects mask |
| wr_data | input | 2+2*NUM_EP | Write data |
| int_status | output | 2+2*NUM_EP | Status bits: 0 config, 1 overrun, then end-of-transfer per endpoint, then request per endpoint |
| force_nak | output | 1 | Answer the current token with NAK |
| irq | output | 1 | Enabled-interrupt summary |

## Verification
The hardest situations to reach are the collisions. One is an event and a software clear hitting the same bit in the same cycle. Another is a setup repeating on an endpoint whose request bit is set, while a clear of that request bit is also in flight. Directed steps build these cases deliberately. A long random phase then drives sparse events, rare clears and a token every cycle. A behavioural model in the bench is compared on every clock, so overlapping holds of different reach meet every endpoint and direction.

// File: rtl/ep_nak_pkg.sv
package ep_nak_pkg;
  localparam int unsigned BIT_CFG     = 0;
  localparam int unsigned BIT_MREQ    = 1;
  localparam int unsigned BIT_EP_BASE = 2;

  typedef enum logic {
    REG_CLEAR = 1'b0,
    REG_MASK  = 1'b1
  } reg_sel_e;

  function automatic int unsigned eot_pos(input int unsigned ep);
    return BIT_EP_BASE + ep;
  endfunction

  function automatic int unsigned req_pos(input int unsigned ep, input int unsigned n_ep);
    return BIT_EP_BASE + n_ep + ep;
  endfunction
endpackage

// File: rtl/ep_event_latch.sv
module ep_event_latch
  import ep_nak_pkg::*;
#(
  parameter int unsigned NUM_EP = 6,
  parameter int unsigned EPW = 3,
  parameter logic [NUM_EP-1:0] BULK_OUT_MASK = 6'b100100
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_evt,
  input  logic                    eot_evt,
  input  logic [EPW-1:0]          eot_ep,
  input  logic                    setup_evt,
  input  logic [EPW-1:0]          setup_ep,
  input  logic                    clr_en,
  input  logic [2+2*NUM_EP-1:0]   clr_bits,
  output logic [2+2*NUM_EP-1:0]   status,
  output logic [2+2*NUM_EP-1:0]   status_d
);
  logic [NUM_EP-1:0] eot_hit, req_hit, eot_q, req_q, eot_d, req_d;
  logic cfg_q, mreq_q, cfg_d, mreq_d;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_EP; gi++) begin : g_ep
      if (BULK_OUT_MASK[gi]) begin : g_bulk
        assign eot_hit[gi] = eot_evt && (eot_ep == EPW'(gi));
      end else begin : g_nonbulk
        assign eot_hit[gi] = 1'b0;
      end
      assign req_hit[gi] = setup_evt && (setup_ep == EPW'(gi));
      // event has priority over a same-cycle clear
      assign eot_d[gi] = eot_hit[gi] ||
                         (eot_q[gi] && !(clr_en && clr_bits[eot_pos(gi)]));
      assign req_d[gi] = req_hit[gi] ||
                         (req_q[gi] && !(clr_en && clr_bits[req_pos(gi, NUM_EP)]));
    end
  endgenerate

  assign cfg_d  = cfg_evt || (cfg_q && !(clr_en && clr_bits[BIT_CFG]));
  assign mreq_d = (|(req_hit & req_q)) ||
                  (mreq_q && !(clr_en && clr_bits[BIT_MREQ]));

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= 1'b0;
      mreq_q <= 1'b0;
      eot_q  <= '0;
      req_q  <= '0;
    end else begin
      cfg_q  <= cfg_d;
      mreq_q <= mreq_d;
      eot_q  <= eot_d;
      req_q  <= req_d;
    end
  end

  assign status   = {req_q, eot_q, mreq_q, cfg_q};
  assign status_d = {req_d, eot_d, mreq_d, cfg_d};
endmodule

// File: rtl/ep_nak_decide.sv
module ep_nak_decide #(
  parameter int unsigned NUM_EP = 6,
  parameter int unsigned EPW = 3
) (
  input  logic              tok_valid,
  input  logic [EPW-1:0]    tok_ep,
  input  logic              tok_dir_in,
  input  logic              cfg_hold,
  input  logic [NUM_EP-1:0] eot_hold,
  input  logic [NUM_EP-1:0] req_hold,
  output logic              force_nak
);
  logic ep_hold;

  always_comb begin
    ep_hold = 1'b0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (tok_ep == EPW'(i)) begin
        ep_hold = req_hold[i] || (eot_hold[i] && !tok_dir_in);
      end
    end
    force_nak = tok_valid && (cfg_hold || ep_hold);
  end
endmodule

// File: rtl/ep_irq_gen.sv
module ep_irq_gen #(
  parameter int unsigned STW = 14
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mask_we,
  input  logic [STW-1:0] mask_data,
  input  logic [STW-1:0] status_d,
  output logic [STW-1:0] mask_q,
  output logic           irq
);
  logic [STW-1:0] mask_d;

  assign mask_d = mask_we ? mask_data : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      irq    <= 1'b0;
    end else begin
      mask_q <= mask_d;
      irq    <= |(status_d & mask_d);
    end
  end
endmodule

// File: rtl/ep_nak_gate.sv
module ep_nak_gate
  import ep_nak_pkg::*;
#(
  parameter int unsigned NUM_EP = 6,
  parameter int unsigned EPW = $clog2(NUM_EP),
  parameter logic [NUM_EP-1:0] BULK_OUT_MASK = 6'b100100
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_evt,
  input  logic                  eot_evt,
  input  logic [EPW-1:0]        eot_ep,
  input  logic                  setup_evt,
  input  logic [EPW-1:0]        setup_ep,
  input  logic                  tok_valid,
  input  logic [EPW-1:0]        tok_ep,
  input  logic                  tok_dir_in,
  input  logic                  wr_en,
  input  logic                  wr_addr,
  input  logic [2+2*NUM_EP-1:0] wr_data,
  output logic [2+2*NUM_EP-1:0] int_status,
  output logic                  force_nak,
  output logic                  irq
);
  localparam int unsigned STW = 2 + 2*NUM_EP;

  reg_sel_e       sel;
  logic           clr_en, mask_we;
  logic [STW-1:0] status_d, mask_q;

  assign sel     = reg_sel_e'(wr_addr);
  assign clr_en  = wr_en && (sel == REG_CLEAR);
  assign mask_we = wr_en && (sel == REG_MASK);

  ep_event_latch #(
    .NUM_EP(NUM_EP), .EPW(EPW), .BULK_OUT_MASK(BULK_OUT_MASK)
  ) u_latch (
    .clk(clk), .rst(rst),
    .cfg_evt(cfg_evt), .eot_evt(eot_evt), .eot_ep(eot_ep),
    .setup_evt(setup_evt), .setup_ep(setup_ep),
    .clr_en(clr_en), .clr_bits(wr_data),
    .status(int_status), .status_d(status_d)
  );

  ep_nak_decide #(.NUM_EP(NUM_EP), .EPW(EPW)) u_decide (
    .tok_valid(tok_valid), .tok_ep(tok_ep), .tok_dir_in(tok_dir_in),
    .cfg_hold(int_status[BIT_CFG]),
    .eot_hold(int_status[BIT_EP_BASE +: NUM_EP]),
    .req_hold(int_status[BIT_EP_BASE+NUM_EP +: NUM_EP]),
    .force_nak(force_nak)
  );

  ep_irq_gen #(.STW(STW)) u_irq (
    .clk(clk), .rst(rst),
    .mask_we(mask_we), .mask_data(wr_data),
    .status_d(status_d), .mask_q(mask_q), .irq(irq)
  );
endmodule

// File: rtl/ep_nak_gate_chk.sv
module ep_nak_gate_chk #(
  parameter int unsigned NUM_EP = 6,
  parameter int unsigned EPW = 3,
  parameter logic [NUM_EP-1:0] BULK_OUT_MASK = 6'b100100
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cfg_evt,
  input logic                  eot_evt,
  input logic [EPW-1:0]        eot_ep,
  input logic                  setup_evt,
  input logic [EPW-1:0]        setup_ep,
  input logic                  tok_valid,
  input logic [EPW-1:0]        tok_ep,
  input logic                  tok_dir_in,
  input logic                  wr_en,
  input logic                  wr_addr,
  input logic [2+2*NUM_EP-1:0] wr_data,
  input logic [2+2*NUM_EP-1:0] int_status,
  input logic [2+2*NUM_EP-1:0] mask_q,
  input logic                  force_nak,
  input logic                  irq
);
  localparam int unsigned PADW = 1 << EPW;
  logic [PADW-1:0] eot_pad, req_pad;

  always_comb begin
    eot_pad = '0;
    req_pad = '0;
    eot_pad[NUM_EP-1:0] = int_status[2 +: NUM_EP];
    req_pad[NUM_EP-1:0] = int_status[2+NUM_EP +: NUM_EP];
  end

  p_cfg_nak_r2: assert property (@(posedge clk) disable iff (rst)
    tok_valid && int_status[0] |-> force_nak);
  p_eot_out_nak_r3: assert property (@(posedge clk) disable iff (rst)
    tok_valid && !tok_dir_in && eot_pad[tok_ep] |-> force_nak);
  p_req_nak_r5: assert property (@(posedge clk) disable iff (rst)
    tok_valid && req_pad[tok_ep] |-> force_nak);
  p_mreq_set_r6: assert property (@(posedge clk) disable iff (rst)
    setup_evt && req_pad[setup_ep] |=> int_status[1]);
  p_cfg_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    int_status[0] && !(wr_en && !wr_addr && wr_data[0]) |=> int_status[0]);
  p_evt_wins_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_evt |=> int_status[0]);
  p_idle_no_nak_r9: assert property (@(posedge clk) disable iff (rst)
    !tok_valid |-> !force_nak);
  p_irq_sum_r10: assert property (@(posedge clk) disable iff (rst)
    irq == |(int_status & mask_q));

  genvar gi;
  generate
    for (gi = 0; gi < NUM_EP; gi++) begin : g_ep
      if (BULK_OUT_MASK[gi]) begin : g_bulk
        p_eot_set_r3: assert property (@(posedge clk) disable iff (rst)
          eot_evt && eot_ep == EPW'(gi) |=> int_status[2+gi]);
      end else begin : g_nonbulk
        p_eot_ignored_r4: assert property (@(posedge clk) disable iff (rst)
          !int_status[2+gi] |=> !int_status[2+gi]);
      end
    end
  endgenerate
endmodule

bind ep_nak_gate ep_nak_gate_chk #(
  .NUM_EP(NUM_EP), .EPW(EPW), .BULK_OUT_MASK(BULK_OUT_MASK)
) i_chk (.*);

// File: tb/test_ep_nak_gate.sv
`timescale 1ns/1ps
module test_ep_nak_gate;
  localparam int NEP = 6;
  localparam int W = 2 + 2*NEP;
  localparam logic [NEP-1:0] BULK = 6'b100100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_evt = 0, eot_evt = 0, setup_evt = 0;
  logic [2:0] eot_ep = 0, setup_ep = 0, tok_ep = 0;
  logic tok_valid = 0, tok_dir_in = 0, wr_en = 0, wr_addr = 0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] int_status;
  logic force_nak, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ep_nak_gate #(.NUM_EP(NEP), .EPW(3), .BULK_OUT_MASK(BULK)) i_ep_nak_gate (
    .clk(clk), .rst(rst), .cfg_evt(cfg_evt), .eot_evt(eot_evt), .eot_ep(eot_ep),
    .setup_evt(setup_evt), .setup_ep(setup_ep), .tok_valid(tok_valid),
    .tok_ep(tok_ep), .tok_dir_in(tok_dir_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .int_status(int_status), .force_nak(force_nak), .irq(irq));

  // behavioural reference model
  bit m_cfg, m_mreq;
  bit m_eot[NEP];
  bit m_req[NEP];
  bit [W-1:0] m_mask;

  function automatic bit [W-1:0] m_status();
    bit [W-1:0] s;
    s = '0;
    s[0] = m_cfg;
    s[1] = m_mreq;
    for (int i = 0; i < NEP; i++) begin
      s[2+i] = m_eot[i];
      s[2+NEP+i] = m_req[i];
    end
    return s;
  endfunction

  function automatic bit m_nak();
    int e;
    e = int'(tok_ep);
    if (!tok_valid) return 0;
    if (m_cfg) return 1;
    if (e >= NEP) return 0;
    return m_req[e] || (m_eot[e] && !tok_dir_in);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cfg = 0; m_mreq = 0; m_mask = '0;
      for (int i = 0; i < NEP; i++) begin m_eot[i] = 0; m_req[i] = 0; end
    end else begin
      bit rep;
      rep = setup_evt && int'(setup_ep) < NEP && m_req[setup_ep];
      if (wr_en && !wr_addr) begin
        if (wr_data[0]) m_cfg = 0;
        if (wr_data[1]) m_mreq = 0;
        for (int i = 0; i < NEP; i++) begin
          if (wr_data[2+i]) m_eot[i] = 0;
          if (wr_data[2+NEP+i]) m_req[i] = 0;
        end
      end
      if (wr_en && wr_addr) m_mask = wr_data;
      if (cfg_evt) m_cfg = 1;
      if (rep) m_mreq = 1;
      if (eot_evt && int'(eot_ep) < NEP && BULK[eot_ep]) m_eot[eot_ep] = 1;
      if (setup_evt && int'(setup_ep) < NEP) m_req[setup_ep] = 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit [W-1:0] s;
      s = m_status();
      chk("R2 cfg bit", 32'(int_status[0]), 32'(s[0]));
      chk("R6 overrun bit", 32'(int_status[1]), 32'(s[1]));
      chk("R3 eot bits", 32'(int_status[2 +: NEP]), 32'(s[2 +: NEP]));
      chk("R5 req bits", 32'(int_status[2+NEP +: NEP]), 32'(s[2+NEP +: NEP]));
      chk("R10 irq", 32'(irq), 32'(|(s & m_mask)));
      chk("R9 force_nak", 32'(force_nak), 32'(m_nak()));
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
    cfg_evt = 0; eot_evt = 0; setup_evt = 0; wr_en = 0;
  endtask

  task automatic probe(input int ep, input bit din, input bit exp, input string tag);
    tok_valid = 1; tok_ep = 3'(ep); tok_dir_in = din;
    #1;
    chk(tag, 32'(force_nak), 32'(exp));
  endtask

  task automatic wr(input bit a, input logic [W-1:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
  endtask

  initial begin
    repeat (3) tick();
    rst = 0;
    #1;
    // R1: reset state
    chk("R1 status after reset", 32'(int_status), 0);
    chk("R1 irq after reset", 32'(irq), 0);
    probe(0, 0, 0, "R1 no nak after reset");
    tick();

    // R2: config change holds all endpoints
    cfg_evt = 1; tick();
    probe(3, 1, 1, "R2 ep3 IN nak");
    probe(0, 0, 1, "R2 ep0 OUT nak");
    wr(0, 14'h0001); tick();
    probe(3, 1, 0, "R7 cfg cleared releases");

    // R3: end of transfer on bulk OUT ep2
    eot_evt = 1; eot_ep = 2; tick();
    probe(2, 0, 1, "R3 ep2 OUT nak");
    probe(2, 1, 0, "R3 ep2 IN unaffected");
    probe(3, 0, 0, "R3 ep3 OUT unaffected");

    // R4: eot on control, non-bulk and out-of-range endpoints
    eot_evt = 1; eot_ep = 0; tick();
    eot_evt = 1; eot_ep = 3; tick();
    eot_evt = 1; eot_ep = 7; tick();
    chk("R4 ignored eot", 32'(int_status), 32'h0010);
    probe(0, 0, 0, "R4 ep0 OUT not held");

    // R5: setup on ep1
    setup_evt = 1; setup_ep = 1; tick();
    probe(1, 0, 1, "R5 ep1 OUT nak");
    probe(1, 1, 1, "R5 ep1 IN nak");
    chk("R6 no overrun yet", 32'(int_status[1]), 0);
    setup_evt = 1; setup_ep = 1; tick();
    chk("R6 overrun set", 32'(int_status[1]), 1);

    // R11: setup beyond endpoint count
    setup_evt = 1; setup_ep = 6; tick();
    chk("R11 ignored setup", 32'(int_status), 32'h0212);

    // R8: event and clear in the same cycle
    setup_evt = 1; setup_ep = 1; wr(0, 14'h0200); tick();
    chk("R8 req ep1 survives", 32'(int_status[9]), 1);
    cfg_evt = 1; wr(0, 14'h0001); tick();
    chk("R8 cfg survives", 32'(int_status[0]), 1);

    // R7: zeros in clear data leave bits alone
    wr(0, 14'h0201); tick();
    chk("R7 partial clear", 32'(int_status), 32'h0012);
    wr(0, 14'h0012); tick();
    chk("R7 full clear", 32'(int_status), 0);

    // R10: mask and irq
    wr(1, 14'h0010); tick();
    chk("R10 irq masked off", 32'(irq), 0);
    eot_evt = 1; eot_ep = 5; tick();
    chk("R10 irq still off ep5", 32'(irq), 0);
    eot_evt = 1; eot_ep = 2; tick();
    chk("R10 irq on", 32'(irq), 1);
    wr(1, 14'h0000); tick();
    chk("R10 irq masked", 32'(irq), 0);

    // random phase
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      cfg_evt = (r[3:0] == 0);
      eot_evt = (r[6:4] == 0);  eot_ep = r[9:7];
      setup_evt = (r[12:10] == 0); setup_ep = r[15:13];
      tok_valid = r[16]; tok_dir_in = r[17]; tok_ep = r[20:18];
      wr_en = (r[23:21] == 0); wr_addr = r[24];
      r = $urandom;
      wr_data = r[W-1:0];
      tick();
    end

    // R1: reset mid-run
    cfg_evt = 1; tick();
    rst = 1; tick(); rst = 0;
    #1;
    chk("R1 status after late reset", 32'(int_status), 0);
    chk("R1 irq after late reset", 32'(irq), 0);
    probe(2, 0, 0, "R1 no nak after late reset");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule